// File: doc/BRIEF.md
# Dual-PROM Readback Error Classifier

This block drives read passes over two configuration PROMs together: one under test and one trusted reference holding the same image. Each PROM returns a byte per read and an active-low end-of-data flag that stays high while data is valid and drops once the image is exhausted. On every read the block compares the two bytes and the two flags. It sorts each disagreement by its signature: a byte difference with the flags still in step, a byte difference at the moment the flags part, flags parting on equal data, or an under-test output that has frozen. Each kind of event has its own saturating counter.

A sequencer repeats the pass as long as a run request is held. Each pass pulses a reset to both PROMs, then enables them until the reference end flag falls or a read limit is reached. A pass that finds a frozen output holds a power-cycle request until the external power controller reports that it has finished. The counters are read through a small address/data port with one cycle of latency.

Top module: `prom_readback_classifier`

## Requirements
- R1: After a run request seen in idle, `dev_rst` is high for exactly one cycle. `dev_en` is then high for one cycle per read, up to and including the read on which `ref_end_n` is low. For an image of L bytes that is L+1 read cycles. `dev_en` and `dev_rst` are never high together.
- R2: A read with `ref_end_n` high, unequal bytes and equal end flags adds one to the bit-error counter. This applies only while the flags have not yet disagreed in the current pass.
- R3: The first read of a pass on which the flags disagree adds one to the address-error counter when `ref_end_n` is high and the bytes differ. A pass adds at most one such error. Byte differences after that read add nothing to the bit-error counter.
- R4: The first flag disagreement of a pass adds one to the end-flag-error counter when the bytes are equal, or when it happens on the read where `ref_end_n` is low.
- R5: A pass ends stuck when the reference byte changed between reads but the under-test byte never did. The held under-test byte picks the counter: 0x00 counts as stuck-low and 0xFF as stuck-high. A stuck pass raises `pwr_req` after its last read and holds it until `pwr_done`. It also adds one to the run-error counter.
- R6: When a pass contains a bit error, the stuck test of R5 only looks at reads after the first bit error. This catches outputs that freeze after that error.
- R7: A pass that makes TIMEOUT reads with `ref_end_n` high ends without a power cycle and adds one to the run-error counter.
- R8: Every finished pass adds one to the run counter. No counter changes except on a read cycle or a clear.
- R9: Every counter stops at all ones.
- R10: A high `clr` at a clock edge sets all counters to zero.
- R11: `rd_data` shows, one cycle after `rd_addr`, the counter it selects. The map is 0 runs, 1 bit errors, 2 address errors, 3 end-flag errors, 4 stuck-low, 5 stuck-high, 6 run errors, and 7 always reads zero.
- R12: While reset is low and right after it is released, `dev_en`, `dev_rst`, `pwr_req` and every counter are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of all counters |
| run_en | input | 1 | Request to start and keep running passes |
| dut_data | input | DW | Byte from the PROM under test |
| dut_end_n | input | 1 | End flag of the PROM under test, low after the last byte |
| ref_data | input | DW | Byte from the reference PROM |
| ref_end_n | input | 1 | End flag of the reference PROM |
| pwr_done | input | 1 | Power controller has cycled power and checked the image |
| rd_addr | input | 3 | Counter select |
| dev_en | output | 1 | Read enable to both PROMs |
| dev_rst | output | 1 | Address-counter reset to both PROMs |
| pwr_req | output | 1 | Power-cycle request |
| rd_data | output | CNT_W | Selected counter value |

## Verification
The properties check, on every cycle, the sequencing rules: enable and reset never overlap, enable only rises after a reset, and a power request only follows a read. They also check that a read stretch never exceeds TIMEOUT, and that each counter moves only by one step on a read cycle, holds at all ones, and is zero after a clear. Which counter a given pattern of byte and flag disagreements lands in can only be shown by the bench scenarios. The same holds for the one-per-pass limit on address errors, the stuck decision with its window reset after the first bit error, and the timeout and power-cycle handshakes.

// File: rtl/pcl_pkg.sv
package pcl_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RST, ST_READ, ST_PWR} seq_st_e;

  localparam int unsigned NUM_CNT  = 8;
  localparam int unsigned IX_RUNS  = 0;
  localparam int unsigned IX_BIT   = 1;
  localparam int unsigned IX_ADDR  = 2;
  localparam int unsigned IX_END   = 3;
  localparam int unsigned IX_S0    = 4;
  localparam int unsigned IX_S1    = 5;
  localparam int unsigned IX_RUNER = 6;
  localparam int unsigned IX_SPARE = 7;
endpackage

// File: rtl/pcl_seq.sv
module pcl_seq
  import pcl_pkg::*;
#(
  parameter int unsigned TIMEOUT = 1 << 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic ref_end_n,
  input  logic pwr_done,
  input  logic stuck_evt,
  output logic dev_en,
  output logic dev_rst,
  output logic pwr_req,
  output logic reading,
  output logic pass_end,
  output logic tmo_end
);
  localparam int unsigned TW = $clog2(TIMEOUT) + 1;

  seq_st_e        st_q, st_d;
  logic [TW-1:0]  rd_q, rd_d;
  logic           tmo_hit;

  // Read-cycle counter and state decode
  always_comb begin
    tmo_hit  = (rd_q == TW'(TIMEOUT - 1));
    reading  = (st_q == ST_READ);
    pass_end = reading & (~ref_end_n | tmo_hit);
    tmo_end  = reading & ref_end_n & tmo_hit;
    dev_en   = reading;
    dev_rst  = (st_q == ST_RST);
    pwr_req  = (st_q == ST_PWR);

    st_d = st_q;
    rd_d = rd_q;
    unique case (st_q)
      ST_IDLE: if (run_en) st_d = ST_RST;
      ST_RST: begin
        rd_d = '0;
        st_d = ST_READ;
      end
      ST_READ: begin
        rd_d = rd_q + 1'b1;
        if (pass_end) begin
          if (stuck_evt)   st_d = ST_PWR;
          else if (run_en) st_d = ST_RST;
          else             st_d = ST_IDLE;
        end
      end
      ST_PWR: if (pwr_done) st_d = run_en ? ST_RST : ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      rd_q <= '0;
    end else begin
      st_q <= st_d;
      rd_q <= rd_d;
    end
  end
endmodule

// File: rtl/pcl_classifier.sv
module pcl_classifier #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pass_clr,
  input  logic          reading,
  input  logic          pass_end,
  input  logic [DW-1:0] dut_data,
  input  logic [DW-1:0] ref_data,
  input  logic          dut_end_n,
  input  logic          ref_end_n,
  output logic          inc_bit,
  output logic          inc_addr,
  output logic          inc_end,
  output logic          stuck0,
  output logic          stuck1
);
  logic          live, diff, mis, first_mis, first_be;
  logic          dut_mv, ref_mv, dut_any, ref_any, cand;
  logic [DW-1:0] held;

  logic          mis_seen_q, mis_seen_d, be_seen_q, be_seen_d;
  logic          have_prev_q, have_prev_d;
  logic          dut_mov_q, dut_mov_d, ref_mov_q, ref_mov_d;
  logic [DW-1:0] dut_prev_q, dut_prev_d, ref_prev_q, ref_prev_d;

  always_comb begin
    live      = reading & ref_end_n;
    diff      = (dut_data != ref_data);
    mis       = (dut_end_n != ref_end_n);
    first_mis = reading & mis & ~mis_seen_q;
    inc_addr  = first_mis & live & diff;
    inc_end   = first_mis & ~(live & diff);
    inc_bit   = live & diff & ~mis & ~mis_seen_q;
    first_be  = inc_bit & ~be_seen_q;
    // movement since the previous read; the first bit error restarts the window
    dut_mv    = live & have_prev_q & (dut_data != dut_prev_q) & ~first_be;
    ref_mv    = live & have_prev_q & (ref_data != ref_prev_q) & ~first_be;
    dut_any   = ~first_be & (dut_mov_q | dut_mv);
    ref_any   = ~first_be & (ref_mov_q | ref_mv);
    held      = live ? dut_data : dut_prev_q;
    cand      = pass_end & ref_any & ~dut_any;
    stuck0    = cand & (held == '0);
    stuck1    = cand & (held == '1);

    mis_seen_d  = mis_seen_q;
    be_seen_d   = be_seen_q;
    have_prev_d = have_prev_q;
    dut_mov_d   = dut_mov_q;
    ref_mov_d   = ref_mov_q;
    dut_prev_d  = dut_prev_q;
    ref_prev_d  = ref_prev_q;
    if (pass_clr) begin
      mis_seen_d  = 1'b0;
      be_seen_d   = 1'b0;
      have_prev_d = 1'b0;
      dut_mov_d   = 1'b0;
      ref_mov_d   = 1'b0;
      dut_prev_d  = '0;
      ref_prev_d  = '0;
    end else begin
      if (reading) mis_seen_d = mis_seen_q | first_mis;
      if (live) begin
        dut_prev_d  = dut_data;
        ref_prev_d  = ref_data;
        have_prev_d = 1'b1;
        be_seen_d   = be_seen_q | first_be;
        dut_mov_d   = dut_any;
        ref_mov_d   = ref_any;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mis_seen_q  <= 1'b0;
      be_seen_q   <= 1'b0;
      have_prev_q <= 1'b0;
      dut_mov_q   <= 1'b0;
      ref_mov_q   <= 1'b0;
      dut_prev_q  <= '0;
      ref_prev_q  <= '0;
    end else begin
      mis_seen_q  <= mis_seen_d;
      be_seen_q   <= be_seen_d;
      have_prev_q <= have_prev_d;
      dut_mov_q   <= dut_mov_d;
      ref_mov_q   <= ref_mov_d;
      dut_prev_q  <= dut_prev_d;
      ref_prev_q  <= ref_prev_d;
    end
  end
endmodule

// File: rtl/pcl_cnt_bank.sv
module pcl_cnt_bank #(
  parameter int unsigned N     = 8,
  parameter int unsigned CNT_W = 32,
  parameter int unsigned AW    = $clog2(N)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic [N-1:0]             inc,
  input  logic [AW-1:0]            rd_addr,
  output logic [CNT_W-1:0]         rd_data,
  output logic [N-1:0][CNT_W-1:0]  cnt
);
  logic [CNT_W-1:0] rd_d;

  for (genvar i = 0; i < N; i++) begin : g_cnt
    logic [CNT_W-1:0] c_d;
    always_comb begin
      c_d = cnt[i];
      if (clr)                        c_d = '0;
      else if (inc[i] && cnt[i] != '1) c_d = cnt[i] + 1'b1;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt[i] <= '0;
      else        cnt[i] <= c_d;
    end
  end

  always_comb rd_d = cnt[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= rd_d;
  end
endmodule

// File: rtl/prom_readback_classifier.sv
module prom_readback_classifier
  import pcl_pkg::*;
#(
  parameter int unsigned DW      = 8,
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned TIMEOUT = 1 << 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run_en,
  input  logic [DW-1:0]    dut_data,
  input  logic             dut_end_n,
  input  logic [DW-1:0]    ref_data,
  input  logic             ref_end_n,
  input  logic             pwr_done,
  input  logic [2:0]       rd_addr,
  output logic             dev_en,
  output logic             dev_rst,
  output logic             pwr_req,
  output logic [CNT_W-1:0] rd_data
);
  logic reading, pass_end, tmo_end;
  logic inc_bit, inc_addr, inc_end, stuck0, stuck1;
  logic [NUM_CNT-1:0]            inc_vec;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_all;

  pcl_seq #(.TIMEOUT(TIMEOUT)) seq_i (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .ref_end_n(ref_end_n),
    .pwr_done(pwr_done), .stuck_evt(stuck0 | stuck1),
    .dev_en(dev_en), .dev_rst(dev_rst), .pwr_req(pwr_req),
    .reading(reading), .pass_end(pass_end), .tmo_end(tmo_end)
  );

  pcl_classifier #(.DW(DW)) cls_i (
    .clk(clk), .rst_n(rst_n), .pass_clr(dev_rst), .reading(reading),
    .pass_end(pass_end), .dut_data(dut_data), .ref_data(ref_data),
    .dut_end_n(dut_end_n), .ref_end_n(ref_end_n),
    .inc_bit(inc_bit), .inc_addr(inc_addr), .inc_end(inc_end),
    .stuck0(stuck0), .stuck1(stuck1)
  );

  always_comb begin
    inc_vec           = '0;
    inc_vec[IX_RUNS]  = pass_end;
    inc_vec[IX_BIT]   = inc_bit;
    inc_vec[IX_ADDR]  = inc_addr;
    inc_vec[IX_END]   = inc_end;
    inc_vec[IX_S0]    = stuck0;
    inc_vec[IX_S1]    = stuck1;
    inc_vec[IX_RUNER] = stuck0 | stuck1 | tmo_end;
    inc_vec[IX_SPARE] = 1'b0;
  end

  pcl_cnt_bank #(.N(NUM_CNT), .CNT_W(CNT_W), .AW(3)) bank_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .inc(inc_vec),
    .rd_addr(rd_addr), .rd_data(rd_data), .cnt(cnt_all)
  );
endmodule

// File: rtl/pcl_checker.sv
module pcl_checker #(
  parameter int unsigned N       = 8,
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned TIMEOUT = 1 << 20
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    clr,
  input logic                    dev_en,
  input logic                    dev_rst,
  input logic                    pwr_req,
  input logic [N-1:0][CNT_W-1:0] cnt_all
);
  logic [31:0] en_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_run <= '0;
    else if (dev_en) en_run <= en_run + 1'b1;
    else             en_run <= '0;
  end

  a_r1_en_rst_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(dev_en && dev_rst));

  a_r1_en_after_rst: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_en) |-> $past(dev_rst));

  a_r5_pwr_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_req) |-> $past(dev_en));

  a_r7_read_window: assert property (@(posedge clk) disable iff (!rst_n)
    en_run <= TIMEOUT);

  for (genvar i = 0; i < N; i++) begin : g_prop
    a_r8_step_in_read: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(clr) && cnt_all[i] != $past(cnt_all[i]))
        |-> ($past(dev_en) && cnt_all[i] == $past(cnt_all[i]) + 1'b1));

    a_r9_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(clr) && $past(cnt_all[i]) == {CNT_W{1'b1}})
        |-> cnt_all[i] == {CNT_W{1'b1}});

    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $past(clr) |-> cnt_all[i] == '0);
  end
endmodule

bind prom_readback_classifier pcl_checker #(
  .N(8), .CNT_W(CNT_W), .TIMEOUT(TIMEOUT)
) chk_i (
  .clk(clk), .rst_n(rst_n), .clr(clr), .dev_en(dev_en),
  .dev_rst(dev_rst), .pwr_req(pwr_req), .cnt_all(cnt_all)
);

// File: tb/prom_readback_classifier_tb_top.sv
module prom_readback_classifier_tb_top;
  localparam int CW  = 8;
  localparam int TMO = 40;
  localparam int LEN = 24;
  localparam int SAT = 255;

  logic          clk = 1'b0;
  logic          rst_n, clr, run_en, pwr_done;
  logic [7:0]    dut_data, ref_data;
  logic          dut_end_n, ref_end_n;
  logic [2:0]    rd_addr;
  logic          dev_en, dev_rst, pwr_req;
  logic [CW-1:0] rd_data;

  int addr;
  int c_len, c_fa, c_mf, c_md, c_sf, c_sv;
  int model [8];
  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  prom_readback_classifier #(.DW(8), .CNT_W(CW), .TIMEOUT(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .run_en(run_en),
    .dut_data(dut_data), .dut_end_n(dut_end_n),
    .ref_data(ref_data), .ref_end_n(ref_end_n),
    .pwr_done(pwr_done), .rd_addr(rd_addr),
    .dev_en(dev_en), .dev_rst(dev_rst), .pwr_req(pwr_req), .rd_data(rd_data)
  );

  function automatic logic [7:0] img(int a);
    return 8'((a * 37 + 5) & 255);
  endfunction

  function automatic int count_ne(int from, int ln, int v);
    int n = 0;
    for (int a = from; a < ln; a++) if (int'(img(a)) != v) n++;
    return n;
  endfunction

  // PROM pair model: address advances on every enabled read
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr <= 0;
    else if (dev_rst) addr <= 0;
    else if (dev_en)  addr <= addr + 1;
  end

  always_comb begin
    logic misal;
    ref_data  = img(addr);
    ref_end_n = (addr < c_len);
    misal     = (c_mf >= 0) && (addr >= c_mf);
    dut_end_n = ref_end_n ^ misal;
    if (c_sf >= 0 && addr >= c_sf) dut_data = 8'(c_sv);
    else dut_data = img(addr) ^ ((addr == c_fa) ? 8'h01 : 8'h00)
                              ^ ((misal && c_md != 0) ? 8'h10 : 8'h00);
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic bump(int i, int n);
    model[i] = (model[i] + n > SAT) ? SAT : model[i] + n;
  endtask

  function automatic string req_of(int i);
    case (i)
      0: return "R8";  1: return "R2";  2: return "R3";  3: return "R4";
      4: return "R5";  5: return "R5";  6: return "R7";  default: return "R11";
    endcase
  endfunction

  task automatic check_all(string tag);
    for (int i = 0; i < 8; i++) begin
      rd_addr = 3'(i);
      @(negedge clk);
      check(int'(rd_data) == model[i], req_of(i), tag, int'(rd_data), model[i]);
    end
  endtask

  task automatic run_pass(int ln, int fa, int mf, int md, int sf, int sv,
                          int exp_reads, bit exp_pwr, string req);
    int en_cnt = 0;
    c_len = ln; c_fa = fa; c_mf = mf; c_md = md; c_sf = sf; c_sv = sv;
    @(negedge clk);
    run_en = 1'b1;
    do @(negedge clk); while (!dev_rst);
    run_en = 1'b0;
    @(negedge clk);
    while (dev_en) begin
      en_cnt++;
      @(negedge clk);
    end
    if (exp_reads > 0) check(en_cnt == exp_reads, req, "read cycles", en_cnt, exp_reads);
    if (exp_pwr) begin
      check(pwr_req == 1'b1, "R5", "power request raised", int'(pwr_req), 1);
      repeat (3) @(negedge clk);
      check(pwr_req == 1'b1, "R5", "power request held", int'(pwr_req), 1);
      pwr_done = 1'b1;
      @(negedge clk);
      pwr_done = 1'b0;
      check(pwr_req == 1'b0, "R5", "power request released", int'(pwr_req), 0);
    end else if (exp_reads > 0) begin
      check(pwr_req == 1'b0, req, "no power request", int'(pwr_req), 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; clr = 1'b0; run_en = 1'b0; pwr_done = 1'b0; rd_addr = '0;
    c_len = LEN; c_fa = -1; c_mf = -1; c_md = 0; c_sf = -1; c_sv = 0;
    for (int i = 0; i < 8; i++) model[i] = 0;
    repeat (3) @(negedge clk);
    check(!dev_en && !dev_rst && !pwr_req, "R12", "outputs in reset", int'({dev_en, dev_rst, pwr_req}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!dev_en && !dev_rst && !pwr_req, "R12", "outputs after reset", int'({dev_en, dev_rst, pwr_req}), 0);
    check_all("R12 counters after reset");

    // clean pass
    run_pass(LEN, -1, -1, 0, -1, 0, LEN + 1, 1'b0, "R1");
    bump(0, 1); check_all("R1 clean pass");

    // single bit flips, first and last data reads
    run_pass(LEN, 0, -1, 0, -1, 0, LEN + 1, 1'b0, "R2");
    bump(0, 1); bump(1, 1); check_all("R2 flip first read");
    run_pass(LEN, LEN - 1, -1, 0, -1, 0, LEN + 1, 1'b0, "R2");
    bump(0, 1); bump(1, 1); check_all("R2 flip last read");

    // address upset: flags part with differing data
    run_pass(LEN, -1, 6, 1, -1, 0, LEN + 1, 1'b0, "R3");
    bump(0, 1); bump(2, 1); check_all("R3 address upset");

    // flags part with equal data
    run_pass(LEN, -1, 6, 0, -1, 0, LEN + 1, 1'b0, "R4");
    bump(0, 1); bump(3, 1); check_all("R4 flag only");

    // under-test flag late: disagreement on the end read only
    run_pass(LEN, -1, LEN, 1, -1, 0, LEN + 1, 1'b0, "R4");
    bump(0, 1); bump(3, 1); check_all("R4 flag late at end");

    // bit error then address upset
    run_pass(LEN, 2, 10, 1, -1, 0, LEN + 1, 1'b0, "R3");
    bump(0, 1); bump(1, 1); bump(2, 1); check_all("R3 bit then address");

    // byte difference after misalignment is not a bit error
    run_pass(LEN, 12, 6, 1, -1, 0, LEN + 1, 1'b0, "R3");
    bump(0, 1); bump(2, 1); check_all("R3 suppression after misalignment");

    // stuck low from the start
    run_pass(LEN, -1, -1, 0, 0, 0, LEN + 1, 1'b1, "R5");
    bump(0, 1); bump(1, count_ne(0, LEN, 0)); bump(4, 1); bump(6, 1);
    check_all("R5 stuck low");

    // stuck high from the start
    run_pass(LEN, -1, -1, 0, 0, 255, LEN + 1, 1'b1, "R5");
    bump(0, 1); bump(1, count_ne(0, LEN, 255)); bump(5, 1); bump(6, 1);
    check_all("R5 stuck high");

    // output freezes high after the first bit error
    run_pass(LEN, -1, -1, 0, 5, 255, LEN + 1, 1'b1, "R6");
    bump(0, 1); bump(1, count_ne(5, LEN, 255)); bump(5, 1); bump(6, 1);
    check_all("R6 freeze after first error");

    // no end flag: read limit
    run_pass(1000, -1, -1, 0, -1, 0, TMO, 1'b0, "R7");
    bump(0, 1); bump(6, 1); check_all("R7 timeout");

    // clear
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    for (int i = 0; i < 8; i++) model[i] = 0;
    check_all("R10 clear");

    // saturation of the run counter
    for (int p = 0; p < SAT + 5; p++) run_pass(LEN, -1, -1, 0, -1, 0, 0, 1'b0, "R9");
    bump(0, SAT + 5);
    check_all("R9 saturation");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule